// File: doc/BRIEF.md
# Protected clock-select control register

This block holds the eight control bits that choose clock sources and stop-mode behaviour for a clock and power management unit. Software reaches it over a simple register bus: an address, a write strobe, write data and combinational read data. Each field also drives its own output pin, so the clock logic downstream needs no decoding.

Writes are filtered bit by bit. A protection-lock input blocks every write. In special mode every bit is writable. In normal mode, five bits are always writable. The stop-mode clock-adjust bit and both watchdog oscillator-select bits are writable only until the watchdog configuration register has been written for the first time. A sideband pulse reports that write, and a latch that only reset clears remembers it. When the oscillator-good input falls, the hardware clears watchdog oscillator-select 0 and grants software one more chance to set it. Watchdog oscillator-select 1 is never touched by the hardware.

Top module: `clk_sel_reg`

## Requirements
- R1: After reset the register reads 0x80: only pll_sel_o is 1 and every other field output is 0.
- R2: rdata_o returns the register whenever addr_i equals REG_ADDR, and returns 0 otherwise. Bit order from bit 7 down to bit 0 is pll_sel, pstop, stop_clk_adj, wdog_osc1, rti_pstop_en, wdog_pstop_en, rti_osc_sel, wdog_osc0. Each field output equals its bit.
- R3: A write while prot_locked_i is 1, or to an address other than REG_ADDR, changes no bit.
- R4: With special_mode_i at 1 and protection open, a write loads all eight bits, even after the watchdog lock has been taken.
- R5: In normal mode with protection open, bits 7, 6, 3, 2 and 1 are loaded by every write.
- R6: In normal mode, bits 5, 4 and 0 are loaded only while the watchdog lock is clear. The lock sets on the clock edge after a wdog_cfg_wr_i pulse, so a write in the same cycle as the pulse still lands. After that the bits hold, and only reset clears the lock.
- R7: A falling edge of osc_ok_i clears wdog_osc0 at the next clock edge. wdog_osc1 keeps its value.
- R8: After a hardware clear of a set wdog_osc0, one normal-mode write may set bit 0 again while the watchdog lock is held. Once that write has set the bit, bit 0 is locked again, and a later write of 0 has no effect.
- R9: When an oscillator fall and a write of 1 to bit 0 land in the same cycle, the hardware clear wins and bit 0 becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register bus address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| prot_locked_i | input | 1 | Protection lock; 1 blocks every write |
| special_mode_i | input | 1 | 1 = special mode, 0 = normal mode |
| wdog_cfg_wr_i | input | 1 | One-cycle pulse when the watchdog configuration register is written |
| osc_ok_i | input | 1 | Oscillator-good status |
| pll_sel_o | output | 1 | Bit 7, PLL select |
| pstop_o | output | 1 | Bit 6, pseudo-stop select |
| stop_clk_adj_o | output | 1 | Bit 5, stop-mode clock adjust |
| wdog_osc1_o | output | 1 | Bit 4, watchdog oscillator select 1 |
| rti_pstop_en_o | output | 1 | Bit 3, real-time interrupt runs in pseudo-stop |
| wdog_pstop_en_o | output | 1 | Bit 2, watchdog runs in pseudo-stop |
| rti_osc_sel_o | output | 1 | Bit 1, real-time interrupt oscillator select |
| wdog_osc0_o | output | 1 | Bit 0, watchdog oscillator select 0 |

## Verification
Read data is combinational, so the bench checks rdata_o 1 ns after it sets addr_i, in the same cycle. A write, a hardware clear and the taking of the watchdog lock each act at the next rising edge. The bench drives every input at the falling edge, compares against its model's state, and then steps the model once per edge. A lock pulse therefore affects only writes from the following cycle on, and an oscillator fall is seen in the cycle in which osc_ok_i is first low.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned BIT_PLL_SEL    = 7;
  localparam int unsigned BIT_PSTOP      = 6;
  localparam int unsigned BIT_STOP_ADJ   = 5;
  localparam int unsigned BIT_WDOG_OSC1  = 4;
  localparam int unsigned BIT_RTI_PSTOP  = 3;
  localparam int unsigned BIT_WDOG_PSTOP = 2;
  localparam int unsigned BIT_RTI_OSC    = 1;
  localparam int unsigned BIT_WDOG_OSC0  = 0;

  localparam logic [REG_W-1:0] RESET_VAL   = 8'h80;
  // normal-mode bits free of the watchdog write-once lock
  localparam logic [REG_W-1:0] ALWAYS_MASK = 8'hCE;
  // normal-mode bits gated by the watchdog write-once lock
  localparam logic [REG_W-1:0] ONCE_MASK   = 8'h31;

  typedef struct packed {
    logic pll_sel;
    logic pstop;
    logic stop_clk_adj;
    logic wdog_osc1;
    logic rti_pstop_en;
    logic wdog_pstop_en;
    logic rti_osc_sel;
    logic wdog_osc0;
  } clk_sel_t;
endpackage

// File: rtl/clk_sel_wdog_lock.sv
module clk_sel_wdog_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdog_cfg_wr_i,
  output logic locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            locked_o <= 1'b0;
    else if (wdog_cfg_wr_i) locked_o <= 1'b1;
  end
endmodule

// File: rtl/clk_sel_osc_mon.sv
module clk_sel_osc_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_ok_i,
  input  logic osc0_set_i,   // current value of watchdog osc select 0
  input  logic consume_i,    // software used the re-set chance
  output logic fall_o,
  output logic rearm_o
);
  logic osc_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) osc_ok_q <= 1'b0;
    else         osc_ok_q <= osc_ok_i;
  end

  assign fall_o = osc_ok_q & ~osc_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rearm_o <= 1'b0;
    else if (fall_o && osc0_set_i) rearm_o <= 1'b1;
    else if (consume_i)           rearm_o <= 1'b0;
  end
endmodule

// File: rtl/clk_sel_perm.sv
module clk_sel_perm
  import clk_sel_pkg::*;
(
  input  logic             special_i,
  input  logic             wdog_locked_i,
  input  logic             rearm_i,
  output logic [REG_W-1:0] load_mask_o,
  output logic             rearm_path_o
);
  always_comb begin
    if (special_i) begin
      load_mask_o  = '1;
      rearm_path_o = 1'b0;
    end else begin
      load_mask_o  = wdog_locked_i ? ALWAYS_MASK : (ALWAYS_MASK | ONCE_MASK);
      rearm_path_o = wdog_locked_i & rearm_i;
    end
  end
endmodule

// File: rtl/clk_sel_reg.sv
module clk_sel_reg
  import clk_sel_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              prot_locked_i,
  input  logic              special_mode_i,
  input  logic              wdog_cfg_wr_i,
  input  logic              osc_ok_i,
  output logic              pll_sel_o,
  output logic              pstop_o,
  output logic              stop_clk_adj_o,
  output logic              wdog_osc1_o,
  output logic              rti_pstop_en_o,
  output logic              wdog_pstop_en_o,
  output logic              rti_osc_sel_o,
  output logic              wdog_osc0_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  clk_sel_t         cfg_q;
  logic [REG_W-1:0] cfg_bits, cfg_next, load_mask;
  logic             hit, wdog_locked, osc_fall, rearm, rearm_path, consume;

  assign cfg_bits = cfg_q;
  assign hit      = wr_en_i && !prot_locked_i && (addr_i == HIT_ADDR);

  clk_sel_wdog_lock u_lock (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wdog_cfg_wr_i (wdog_cfg_wr_i),
    .locked_o      (wdog_locked)
  );

  clk_sel_perm u_perm (
    .special_i     (special_mode_i),
    .wdog_locked_i (wdog_locked),
    .rearm_i       (rearm),
    .load_mask_o   (load_mask),
    .rearm_path_o  (rearm_path)
  );

  // one-shot re-set of osc select 0 is spent by a write of 1 through it
  assign consume = hit && rearm_path && wdata_i[BIT_WDOG_OSC0];

  clk_sel_osc_mon u_osc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_ok_i   (osc_ok_i),
    .osc0_set_i (cfg_q.wdog_osc0),
    .consume_i  (consume),
    .fall_o     (osc_fall),
    .rearm_o    (rearm)
  );

  always_comb begin
    cfg_next = cfg_bits;
    if (hit) begin
      cfg_next = (cfg_bits & ~load_mask) | (wdata_i & load_mask);
      if (consume) cfg_next[BIT_WDOG_OSC0] = 1'b1;
    end
    if (osc_fall) cfg_next[BIT_WDOG_OSC0] = 1'b0;  // hardware clear wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= clk_sel_t'(RESET_VAL);
    else         cfg_q <= clk_sel_t'(cfg_next);
  end

  assign rdata_o         = (addr_i == HIT_ADDR) ? cfg_bits : '0;
  assign pll_sel_o       = cfg_q.pll_sel;
  assign pstop_o         = cfg_q.pstop;
  assign stop_clk_adj_o  = cfg_q.stop_clk_adj;
  assign wdog_osc1_o     = cfg_q.wdog_osc1;
  assign rti_pstop_en_o  = cfg_q.rti_pstop_en;
  assign wdog_pstop_en_o = cfg_q.wdog_pstop_en;
  assign rti_osc_sel_o   = cfg_q.rti_osc_sel;
  assign wdog_osc0_o     = cfg_q.wdog_osc0;
endmodule

// File: rtl/clk_sel_reg_chk.sv
module clk_sel_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       prot_locked_i,
  input logic       special_mode_i,
  input logic       osc_fall,
  input logic       wdog_locked,
  input logic [7:0] fields
);
  assert_locked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_locked_i && !osc_fall) |=> (fields == $past(fields)));

  assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_locked |=> wdog_locked);

  assert_once_bits_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_locked && !special_mode_i) |=> (fields[5:4] == $past(fields[5:4])));

  assert_fall_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_fall |=> !fields[0]);

  assert_osc1_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_fall && !wr_en_i) |=> (fields[4] == $past(fields[4])));
endmodule

bind clk_sel_reg clk_sel_reg_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .prot_locked_i  (prot_locked_i),
  .special_mode_i (special_mode_i),
  .osc_fall       (osc_fall),
  .wdog_locked    (wdog_locked),
  .fields         ({pll_sel_o, pstop_o, stop_clk_adj_o, wdog_osc1_o,
                    rti_pstop_en_o, wdog_pstop_en_o, rti_osc_sel_o, wdog_osc0_o})
);

// File: tb/sim_clk_sel_reg.sv
module sim_clk_sel_reg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned REG_A  = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 0, prot = 0, spec = 0, wd = 0, osc = 1;
  logic [7:0] wdata = '0, rdata;
  logic pll, pst, adj, o1, rpe, wpe, ros, o0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_reg;
  logic m_lock, m_rearm, m_osc_prev;

  always #2 clk = ~clk;

  clk_sel_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_A)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .prot_locked_i(prot), .special_mode_i(spec),
    .wdog_cfg_wr_i(wd), .osc_ok_i(osc),
    .pll_sel_o(pll), .pstop_o(pst), .stop_clk_adj_o(adj), .wdog_osc1_o(o1),
    .rti_pstop_en_o(rpe), .wdog_pstop_en_o(wpe), .rti_osc_sel_o(ros), .wdog_osc0_o(o0));

  function automatic logic [7:0] exp_rd(logic [7:0] r, logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(REG_A)) ? r : 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_reg = 8'h80; m_lock = 0; m_rearm = 0; m_osc_prev = 0;
  endtask

  task automatic model_step();
    logic [7:0] m, nxt;
    logic hit, fall, cons;
    hit  = wr && !prot && (addr == ADDR_W'(REG_A));
    fall = m_osc_prev && !osc;
    m    = spec ? 8'hFF : (m_lock ? 8'hCE : 8'hFF);
    nxt  = hit ? ((m_reg & ~m) | (wdata & m)) : m_reg;
    cons = hit && !spec && m_lock && m_rearm && wdata[0];
    if (cons) nxt[0] = 1'b1;
    if (fall) nxt[0] = 1'b0;
    if (fall && m_reg[0]) m_rearm = 1;
    else if (cons)        m_rearm = 0;
    m_lock     = m_lock | wd;
    m_osc_prev = osc;
    m_reg      = nxt;
  endtask

  // drive at negedge, check comb read 1 ns later, advance one edge
  task automatic step(string req, logic w, logic [ADDR_W-1:0] a, logic [7:0] d,
                      logic p, logic s, logic k, logic ok);
    wr = w; addr = a; wdata = d; prot = p; spec = s; wd = k; osc = ok;
    #1;
    check(req, rdata, exp_rd(m_reg, a));
    check(req, {pll, pst, adj, o1, rpe, wpe, ros, o0}, m_reg);
    model_step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; wr = 0; wd = 0; osc = 1; prot = 0; spec = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  localparam logic [ADDR_W-1:0] RA = ADDR_W'(REG_A);

  initial begin
    int seed;
    seed = 32'h5EED_0007;
    void'($urandom(seed));
    @(negedge clk);
    do_reset();
    #1;
    check("R1", {pll, pst, adj, o1, rpe, wpe, ros, o0}, 8'h80);
    addr = RA; #1; check("R1", rdata, 8'h80);
    @(negedge clk);

    step("R2", 0, 4'h3, 8'h00, 0, 0, 0, 1);          // other address reads 0
    step("R3", 1, RA, 8'h7F, 1, 0, 0, 1);            // locked write ignored
    step("R3", 1, 4'h2, 8'h7F, 0, 0, 0, 1);          // wrong address ignored
    step("R3", 0, RA, 8'h00, 0, 0, 0, 1);
    step("R5", 1, RA, 8'h4F, 0, 0, 0, 1);            // normal, before lock: all
    step("R6", 1, RA, 8'h71, 0, 0, 1, 1);            // same cycle as lock pulse
    step("R6", 1, RA, 8'h0E, 0, 0, 0, 1);            // 5,4,0 now hold
    step("R6", 1, RA, 8'hC0, 0, 0, 0, 1);
    step("R7", 0, RA, 8'h00, 0, 0, 0, 0);            // osc falls
    step("R7", 0, RA, 8'h00, 0, 0, 0, 0);            // bit0 cleared, bit4 kept
    step("R8", 1, RA, 8'h01, 0, 0, 0, 1);            // one-shot re-set
    step("R8", 1, RA, 8'h00, 0, 0, 0, 1);            // now locked again
    step("R8", 0, RA, 8'h00, 0, 0, 0, 1);
    step("R9", 1, RA, 8'h01, 0, 1, 0, 0);            // fall + write 1, clear wins
    step("R4", 1, RA, 8'h3F, 0, 1, 0, 1);            // special: all bits
    step("R4", 1, RA, 8'h00, 0, 1, 0, 1);
    step("R4", 0, RA, 8'h00, 0, 0, 0, 1);

    for (int ph = 0; ph < 4; ph++) begin
      do_reset();
      @(negedge clk);
      for (int i = 0; i < 1500; i++) begin
        logic [ADDR_W-1:0] a;
        a = ($urandom_range(0, 3) != 0) ? RA : ADDR_W'($urandom);
        step("R2/R3/R4/R5/R6/R7/R8/R9", $urandom_range(0, 2) != 0, a, 8'($urandom),
             $urandom_range(0, 5) == 0, $urandom_range(0, 6) == 0,
             $urandom_range(0, 60) == 0,
             ($urandom_range(0, 12) == 0) ? !osc : osc);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule